// File: doc/BRIEF.md
# Masked Packed Unsigned-to-Float Narrowing Converter

This block turns up to eight packed 64-bit unsigned integers into IEEE-754 single-precision values in a single step, and writes them into a 256-bit packed result. A vector-length select sets how many lanes are active: two, four or eight. A lane mask, together with a mask-enable flag, chooses which active lanes receive a converted value. An active lane that is not chosen either keeps the matching lane of the old destination value (merging) or is cleared (zeroing). Result lanes above the active count always read zero.

Each conversion is correctly rounded in one of four modes. The mode normally comes from a default rounding input. A per-operation rounding field replaces it, but only at full vector length and only when its enable bit is set. The block also checks a 4-bit reserved register-specifier field. Any value other than all-ones marks the operation as illegal, and the result register is then left untouched. An inexact flag reports that some written lane lost precision. The result and both flags are registered on a valid strobe and hold their values between strobes.

Top module: `pku2f_conv`

## Requirements
- R1: Lane j converts source bits [64j+63:64j] into result bits [32j+31:32j]. The vector length `vlen_i` selects the active lane count: 2'b00 gives 2 lanes, 2'b01 gives 4 lanes, and 2'b10 or 2'b11 gives 8 lanes.
- R2: Result lanes at or above the active lane count are written as zero, whatever the mask, mode and old destination value.
- R3: The source is unsigned, and the result is the correctly rounded float32 value. With rounding code 0 (nearest, ties to even), 0x1000001 gives 0x4B800000, 0x1000003 gives 0x4B800002 and 0xFFFFFF gives 0x4B7FFFFF. Bit 31 of every lane is 0.
- R4: Rounding code 1 rounds toward minus infinity, code 2 toward plus infinity and code 3 toward zero. For example, 0x1000001 gives 0x4B800001 under code 2 and 0x4B800000 under codes 1 and 3.
- R5: The rounding field `er_rc_i` replaces `dflt_rc_i` only when `er_en_i` is 1 and the vector length selects 8 lanes. Otherwise `dflt_rc_i` is used.
- R6: An active lane is written with its converted value when `mask_en_i` is 0 or when its bit in `mask_i` is 1.
- R7: An active lane that is not written keeps the matching 32-bit lane of `old_dst_i` when `zero_mode_i` is 0, and becomes 0 when `zero_mode_i` is 1.
- R8: When `spec_i` is not 4'b1111, a strobe sets `illegal_o` to 1 and `inexact_o` to 0, and leaves `result_o` unchanged. A strobe with 4'b1111 clears `illegal_o`.
- R9: `inexact_o` is the OR, over written lanes only, of "the discarded low-order bits were nonzero".
- R10: A source of 0 gives 0x00000000 and is exact. A source of 2^64-1 gives 0x5F800000 under codes 0 and 2, and 0x5F7FFFFF under codes 1 and 3. A source of 2^63 gives 0x5F000000 and is exact.
- R11: Outputs take new values at the clock edge that samples `valid_i` high, and hold without a strobe. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| src_i | input | 512 | Packed 64-bit unsigned source lanes |
| vlen_i | input | 2 | Vector length: 00=2 lanes, 01=4 lanes, 1x=8 lanes |
| mask_i | input | 8 | Per-lane write mask |
| mask_en_i | input | 1 | 1 = apply the mask |
| zero_mode_i | input | 1 | 1 = zero unwritten lanes, 0 = merge |
| er_en_i | input | 1 | Per-operation rounding enable |
| er_rc_i | input | 2 | Per-operation rounding code |
| dflt_rc_i | input | 2 | Default rounding code |
| spec_i | input | 4 | Reserved field; must be 4'b1111 |
| old_dst_i | input | 256 | Previous destination value for merging |
| result_o | output | 256 | Packed float32 result lanes |
| illegal_o | output | 1 | Reserved-field violation on the last strobe |
| inexact_o | output | 1 | Precision lost in a written lane |

## Verification
Every result and both flags are due at the first rising edge after `valid_i` goes high. Nothing arrives later, because the conversion is combinational ahead of one register stage. The bench changes inputs on the falling edge and raises the strobe for exactly one cycle. It then samples on the next falling edge, half a cycle after the capturing edge. Hold behaviour is checked on a later falling edge with the strobe low and the inputs changed.

// File: rtl/pku2f_pkg.sv
package pku2f_pkg;
  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_DOWN = 2'd1,
    RND_UP   = 2'd2,
    RND_ZERO = 2'd3
  } rnd_mode_e;

  localparam logic [3:0] SPEC_OK = 4'b1111;
endpackage

// File: rtl/pku2f_ctrl.sv
module pku2f_ctrl
  import pku2f_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [1:0]       vlen_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             mask_en_i,
  input  logic             er_en_i,
  input  logic [1:0]       er_rc_i,
  input  logic [1:0]       dflt_rc_i,
  input  logic [3:0]       spec_i,
  output rnd_mode_e        rnd_o,
  output logic [LANES-1:0] active_o,
  output logic [LANES-1:0] write_o,
  output logic             illegal_o
);
  localparam int QUART = LANES / 4;
  localparam int HALF  = LANES / 2;

  logic full_len;
  int   lane_cnt;

  always_comb begin
    full_len = vlen_i[1];
    case (vlen_i)
      2'b00:   lane_cnt = QUART;
      2'b01:   lane_cnt = HALF;
      default: lane_cnt = LANES;
    endcase
    rnd_o = (full_len && er_en_i) ? rnd_mode_e'(er_rc_i) : rnd_mode_e'(dflt_rc_i);
    for (int j = 0; j < LANES; j++) begin
      active_o[j] = (j < lane_cnt);
    end
    write_o   = active_o & (mask_en_i ? mask_i : {LANES{1'b1}});
    illegal_o = (spec_i != SPEC_OK);
  end

  always_comb begin
    AST_WRITE_INSIDE_ACTIVE: assert ((write_o & ~active_o) == '0); // R2
  end
endmodule

// File: rtl/pku2f_lane.sv
module pku2f_lane
  import pku2f_pkg::*;
#(
  parameter int IN_W  = 64,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [IN_W-1:0]        src_i,
  input  rnd_mode_e              rnd_i,
  output logic [EXP_W+MAN_W:0]   fp_o,
  output logic                   inexact_o
);
  localparam int FP_W = EXP_W + MAN_W + 1;
  localparam int LZ_W = $clog2(IN_W);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int G_POS = IN_W - 2 - MAN_W;

  logic [LZ_W:0]      lz;
  logic               found;
  logic               nonzero;
  logic [IN_W-1:0]    norm;
  logic [MAN_W-1:0]   mant;
  logic [EXP_W-1:0]   expo;
  logic               guard;
  logic               sticky;
  logic               bump;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int b = IN_W - 1; b >= 0; b--) begin
      if (!found) begin
        if (src_i[b]) found = 1'b1;
        else          lz    = lz + 1'b1;
      end
    end
  end

  always_comb begin
    nonzero = |src_i;
    norm    = src_i << lz[LZ_W-1:0];
    mant    = norm[IN_W-2 -: MAN_W];
    guard   = norm[G_POS];
    sticky  = |norm[G_POS-1:0];
    expo    = EXP_W'(BIAS + IN_W - 1 - int'(lz));
    case (rnd_i)
      RND_NEAR: bump = guard && (sticky || mant[0]);
      RND_UP:   bump = guard || sticky;
      default:  bump = 1'b0;
    endcase
    if (nonzero) fp_o = {1'b0, expo, mant} + FP_W'(bump);
    else         fp_o = '0;
    inexact_o = nonzero && (guard || sticky);
  end

  always_comb begin
    if (src_i == '0) begin
      AST_ZERO_EXACT: assert (fp_o == '0 && !inexact_o); // R10
    end
    AST_SIGN_CLEAR: assert (!fp_o[FP_W-1]); // R3
  end
endmodule

// File: rtl/pku2f_conv.sv
module pku2f_conv
  import pku2f_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IN_W  = 64,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              valid_i,
  input  logic [LANES*IN_W-1:0]             src_i,
  input  logic [1:0]                        vlen_i,
  input  logic [LANES-1:0]                  mask_i,
  input  logic                              mask_en_i,
  input  logic                              zero_mode_i,
  input  logic                              er_en_i,
  input  logic [1:0]                        er_rc_i,
  input  logic [1:0]                        dflt_rc_i,
  input  logic [3:0]                        spec_i,
  input  logic [LANES*(EXP_W+MAN_W+1)-1:0]  old_dst_i,
  output logic [LANES*(EXP_W+MAN_W+1)-1:0]  result_o,
  output logic                              illegal_o,
  output logic                              inexact_o
);
  localparam int OUT_W = EXP_W + MAN_W + 1;
  localparam int DST_W = LANES * OUT_W;
  localparam int SHORT_W = (LANES / 4) * OUT_W;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rnd_mode_e        rnd;
  logic [LANES-1:0] active;
  logic [LANES-1:0] write;
  logic             illegal;
  logic [LANES-1:0] lane_inex;
  logic [DST_W-1:0] conv;
  logic [DST_W-1:0] result_d;

  pku2f_ctrl #(.LANES(LANES)) u_ctrl (
    .vlen_i    (vlen_i),
    .mask_i    (mask_i),
    .mask_en_i (mask_en_i),
    .er_en_i   (er_en_i),
    .er_rc_i   (er_rc_i),
    .dflt_rc_i (dflt_rc_i),
    .spec_i    (spec_i),
    .rnd_o     (rnd),
    .active_o  (active),
    .write_o   (write),
    .illegal_o (illegal)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    pku2f_lane #(.IN_W(IN_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
      .src_i     (src_i[j*IN_W +: IN_W]),
      .rnd_i     (rnd),
      .fp_o      (conv[j*OUT_W +: OUT_W]),
      .inexact_o (lane_inex[j])
    );

    always_comb begin
      if (write[j])
        result_d[j*OUT_W +: OUT_W] = conv[j*OUT_W +: OUT_W];
      else if (active[j] && !zero_mode_i)
        result_d[j*OUT_W +: OUT_W] = old_dst_i[j*OUT_W +: OUT_W];
      else
        result_d[j*OUT_W +: OUT_W] = '0;
    end
  end

  logic [DST_W-1:0] res_q, res_n;
  logic             ill_q, ill_n;
  logic             inx_q, inx_n;

  always_comb begin
    res_n = res_q;
    ill_n = ill_q;
    inx_n = inx_q;
    if (valid_i) begin
      ill_n = illegal;
      inx_n = !illegal && (|(write & lane_inex));
      if (!illegal) res_n = result_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      res_q <= '0;
      ill_q <= 1'b0;
      inx_q <= 1'b0;
    end else begin
      res_q <= res_n;
      ill_q <= ill_n;
      inx_q <= inx_n;
    end
  end

  assign result_o  = res_q;
  assign illegal_o = ill_q;
  assign inexact_o = inx_q;

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    valid_i && spec_i != SPEC_OK |=> illegal_o && !inexact_o && result_o == $past(result_o)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !valid_i |=> $stable(result_o) && $stable(illegal_o) && $stable(inexact_o)); // R11
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_q)
    valid_i && spec_i == SPEC_OK && vlen_i == 2'b00 |=> result_o[DST_W-1:SHORT_W] == '0); // R2
  AST_ZERO_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    valid_i && spec_i == SPEC_OK && mask_en_i && zero_mode_i && mask_i == '0
    |=> result_o == '0 && !inexact_o); // R7
  AST_MERGE_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    valid_i && spec_i == SPEC_OK && vlen_i[1] && mask_en_i && !zero_mode_i && mask_i == '0
    |=> result_o == $past(old_dst_i) && !inexact_o); // R7
endmodule

// File: tb/pku2f_conv_bench.sv
`timescale 1ns/1ps
module pku2f_conv_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid;
  logic [511:0] src;
  logic [1:0]   vlen;
  logic [7:0]   mask;
  logic         mask_en, zero_mode, er_en;
  logic [1:0]   er_rc, dflt_rc;
  logic [3:0]   spec;
  logic [255:0] old_dst;
  logic [255:0] result;
  logic         illegal, inexact;

  int runs = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pku2f_conv u_pku2f_conv (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .src_i(src), .vlen_i(vlen),
    .mask_i(mask), .mask_en_i(mask_en), .zero_mode_i(zero_mode), .er_en_i(er_en),
    .er_rc_i(er_rc), .dflt_rc_i(dflt_rc), .spec_i(spec), .old_dst_i(old_dst),
    .result_o(result), .illegal_o(illegal), .inexact_o(inexact)
  );

  // {value, rounding code, expected float32, expected inexact}
  localparam logic [98:0] VECS [14] = '{
    {64'h1, 2'd0, 32'h3F800000, 1'b0},
    {64'h0, 2'd0, 32'h00000000, 1'b0},
    {64'h3, 2'd3, 32'h40400000, 1'b0},
    {64'hFFFFFF, 2'd0, 32'h4B7FFFFF, 1'b0},
    {64'h1000001, 2'd0, 32'h4B800000, 1'b1},
    {64'h1000001, 2'd2, 32'h4B800001, 1'b1},
    {64'h1000001, 2'd1, 32'h4B800000, 1'b1},
    {64'h1000003, 2'd0, 32'h4B800002, 1'b1},
    {64'h1000003, 2'd3, 32'h4B800001, 1'b1},
    {64'hFFFFFFFFFFFFFFFF, 2'd0, 32'h5F800000, 1'b1},
    {64'hFFFFFFFFFFFFFFFF, 2'd3, 32'h5F7FFFFF, 1'b1},
    {64'hFFFFFFFFFFFFFFFF, 2'd2, 32'h5F800000, 1'b1},
    {64'hFFFFFFFFFFFFFFFF, 2'd1, 32'h5F7FFFFF, 1'b1},
    {64'h8000000000000000, 2'd1, 32'h5F000000, 1'b0}
  };

  // float32 of small integers 1..8
  localparam logic [31:0] SMALL [8] = '{32'h3F800000, 32'h40000000, 32'h40400000,
    32'h40800000, 32'h40A00000, 32'h40C00000, 32'h40E00000, 32'h41000000};

  task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic defaults();
    valid = 1'b0; src = '0; vlen = 2'b10; mask = '0; mask_en = 1'b0;
    zero_mode = 1'b0; er_en = 1'b0; er_rc = 2'd0; dflt_rc = 2'd0;
    spec = 4'b1111; old_dst = '0;
  endtask

  // inputs already set; strobe for one cycle, sample on the next falling edge
  task automatic strobe();
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic small_src();
    for (int j = 0; j < 8; j++) src[j*64 +: 64] = 64'(j + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    runs++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [255:0] exp;
    defaults();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 reset result", result, '0);
    chk("R11 reset flags", {254'b0, illegal, inexact}, '0);

    // table: all eight lanes carry the same value, default rounding
    for (int v = 0; v < 14; v++) begin
      defaults();
      src = {8{VECS[v][98:35]}};
      dflt_rc = VECS[v][34:33];
      strobe();
      chk($sformatf("R3/R4/R10 table %0d value", v), result, {8{VECS[v][32:1]}});
      chk($sformatf("R9 table %0d inexact", v), {255'b0, inexact}, {255'b0, VECS[v][0]});
    end

    // R1 R2: lane placement and length
    defaults(); small_src(); vlen = 2'b00; old_dst = {8{32'hA5A5A5A5}};
    strobe();
    chk("R1/R2 two lanes", result, {192'b0, SMALL[1], SMALL[0]});
    defaults(); small_src(); vlen = 2'b01; zero_mode = 1'b0; old_dst = {8{32'hA5A5A5A5}};
    strobe();
    chk("R1/R2 four lanes", result, {128'b0, SMALL[3], SMALL[2], SMALL[1], SMALL[0]});
    defaults(); small_src(); vlen = 2'b11;
    strobe();
    exp = '0;
    for (int j = 0; j < 8; j++) exp[j*32 +: 32] = SMALL[j];
    chk("R1 eight lanes", result, exp);

    // R6 R7: masking, merge then zero
    defaults(); small_src(); mask_en = 1'b1; mask = 8'b1010_0101;
    old_dst = {8{32'hA5A5A5A5}};
    strobe();
    for (int j = 0; j < 8; j++) exp[j*32 +: 32] = mask[j] ? SMALL[j] : 32'hA5A5A5A5;
    chk("R6/R7 merge", result, exp);
    defaults(); small_src(); mask_en = 1'b1; mask = 8'b1010_0101; zero_mode = 1'b1;
    old_dst = {8{32'hA5A5A5A5}};
    strobe();
    for (int j = 0; j < 8; j++) exp[j*32 +: 32] = mask[j] ? SMALL[j] : 32'h0;
    chk("R6/R7 zeroing", result, exp);
    defaults(); small_src(); mask_en = 1'b0; mask = 8'h00; zero_mode = 1'b1;
    strobe();
    for (int j = 0; j < 8; j++) exp[j*32 +: 32] = SMALL[j];
    chk("R6 mask disabled", result, exp);

    // R5: per-operation rounding only at full length
    defaults(); src = {8{64'h1000001}}; er_en = 1'b1; er_rc = 2'd2; dflt_rc = 2'd0;
    strobe();
    chk("R5 override at 512", result, {8{32'h4B800001}});
    defaults(); src = {8{64'h1000001}}; vlen = 2'b01; er_en = 1'b1; er_rc = 2'd2;
    strobe();
    chk("R5 no override at 256", result, {128'b0, {4{32'h4B800000}}});
    defaults(); src = {8{64'h1000001}}; er_en = 1'b0; er_rc = 2'd2; dflt_rc = 2'd3;
    strobe();
    chk("R5 override disabled", result, {8{32'h4B800000}});

    // R9: inexact from written lanes only
    defaults(); src[63:0] = 64'h1000001; src[127:64] = 64'h1; vlen = 2'b00;
    mask_en = 1'b1; mask = 8'b0000_0010;
    strobe();
    chk("R9 masked lane not flagged", {255'b0, inexact}, '0);
    chk("R9 masked lane result", result, {192'b0, 32'h3F800000, 32'h0});
    defaults(); src[63:0] = 64'h1000001; vlen = 2'b00; mask_en = 1'b1; mask = 8'b0000_0001;
    strobe();
    chk("R9 written lane flagged", {255'b0, inexact}, {255'b0, 1'b1});
    defaults(); src[63:0] = 64'h1000001; src[255:192] = 64'h1000001; vlen = 2'b00;
    defaults(); src[255:192] = 64'h1000001; vlen = 2'b00;
    strobe();
    chk("R9 R2 inactive lane not flagged", {255'b0, inexact}, '0);

    // R8: illegal reserved field
    defaults(); small_src();
    strobe();
    for (int j = 0; j < 8; j++) exp[j*32 +: 32] = SMALL[j];
    defaults(); src = {8{64'h1000001}}; spec = 4'b0111;
    strobe();
    chk("R8 result kept", result, exp);
    chk("R8 flags", {254'b0, illegal, inexact}, {254'b0, 2'b10});
    defaults(); src = {8{64'h3}};
    strobe();
    chk("R8 flag clears", {254'b0, illegal, inexact}, '0);

    // R11: hold without strobe
    defaults(); src = {8{64'hFFFF}}; spec = 4'b0000; mask_en = 1'b1; zero_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 hold result", result, {8{32'h40400000}});
    chk("R11 hold flags", {254'b0, illegal, inexact}, '0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule